// File: doc/BRIEF.md
# BCD Clock Calendar Counter Chain

This block keeps time of day and calendar date as a chain of packed BCD registers. A built-in prescaler turns the system clock into a 1/100-second tick enable. Each tick advances the hundredths register, and carries ripple through seconds, minutes, hours, the date and the month. A 2-bit year shares a byte with the date, and a 3-bit weekday shares a byte with the month. The hours byte holds its own 12/24-hour format bit and an AM/PM bit.

Software-style access uses a byte write port that addresses one counter location at a time, and a read port. The read port never looks at the live counters. A one-cycle read-start strobe copies all six counters into a capture bank, and the read data comes from that bank. This prevents a torn value while a carry is in flight. Three level controls adjust this behaviour. The stop input halts counting and clears the prescaler. The hold input freezes the capture bank at its last contents. The mask input zeroes the year and weekday fields on reads.

Top module: `bcd_rtc_chain`

## Requirements
- R1: After reset, reads of locations 0 through 5 return 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01 (00:00:00.00 on day 01 of month 01, year 0, weekday 0, 24-hour format).
- R2: Location 0 (hundredths) counts 00–99 and locations 1 (seconds) and 2 (minutes) count 00–59, all BCD. Each wraps to 00 and carries one step into the next location.
- R3: Location 3 (hours) has bits 3:0 unit hours, bits 5:4 ten hours, bit 6 PM and bit 7 format (1 = 12 h). In 24-hour format the hours run 00–23, the step 23→00 carries into the date, and bit 6 keeps its value.
- R4: In 12-hour format the hours run 12, 01 … 11. The PM bit toggles on the step 11→12. The date advances only on the step from 11 PM to 12 AM.
- R5: Location 4 holds unit days in bits 3:0, ten days in bits 5:4 and year in bits 7:6. The last date is 31 for months 01, 03, 05, 07, 08, 10 and 12, and 30 for months 04, 06, 09 and 11. For month 02 the last date is 29 when year is 0 and 28 otherwise. After the last date, the date returns to 01.
- R6: Location 5 holds unit months in bits 3:0, ten months in bit 4 and weekday in bits 7:5. The weekday steps 0–6 on every date advance and wraps to 0. The month steps 01–12 and wraps to 01. The year increments, modulo 4, when month 12 wraps.
- R7: While the mask input is high, reads of locations 4 and 5 return 0 in the year and weekday fields. Other fields and other locations read unchanged.
- R8: A read-start strobe on a clock edge copies every counter into the capture bank. The read data is the captured byte at the read address, and it does not follow later counting until the next strobe.
- R9: While hold is high, a read-start strobe does not update the capture bank.
- R10: While stop is high no counter advances, and the prescaler returns to its initial phase. After stop falls, the first tick comes TICK_DIV cycles later.
- R11: A write updates only the addressed location. Writes to addresses 6 and 7 change nothing, and reads of those addresses return 8'h00.
- R12: With stop low, the prescaler issues one tick every TICK_DIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_i | input | 1 | Halt counting and clear the prescaler |
| hold_i | input | 1 | Freeze the capture bank |
| mask_i | input | 1 | Zero year and weekday fields on read |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 3 | Write location |
| wr_data_i | input | 8 | Write byte |
| rd_start_i | input | 1 | Read-start strobe that loads the capture bank |
| rd_addr_i | input | 3 | Read location |
| rd_data_o | output | 8 | Captured byte, masked as selected |

## Verification
A wrong carry decision shows up as a bad byte in the next location up on the first tick after the faulty value. A read right after that tick exposes it, so the bench loads each rollover value and then runs exactly one tick. A fault in the month-length or 12-hour logic stays hidden until the date or hours byte reaches its boundary, so each boundary is loaded directly rather than reached by counting. A capture or hold fault appears on the first read after counting has moved on, because the read data then either follows or fails to follow the live counters.

// File: rtl/bcd_rtc_chain.sv
module bcd_rtc_chain #(
  parameter int TICK_DIV = 328
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_i,
  input  logic       hold_i,
  input  logic       mask_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic       rd_start_i,
  input  logic [2:0] rd_addr_i,
  output logic [7:0] rd_data_o
);
  localparam int DW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(TICK_DIV - 1);

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic lo9;
    lo9 = (v[3:0] == 4'd9);
    return {v[7:4] + {3'b000, lo9}, lo9 ? 4'd0 : v[3:0] + 4'd1};
  endfunction

  logic [DW-1:0] div_q;
  logic          tick;
  logic [7:0]    hs_q, sec_q, min_q, hr_q, yd_q, wm_q;
  logic [7:0]    cap_hs, cap_sec, cap_min, cap_hr, cap_yd, cap_wm;

  assign tick = !stop_i && (div_q == DIV_LAST);

  logic c_hs, c_sec, c_min, c_day, c_mon, c_yr;
  logic roll_h, roll_d, roll_m;
  logic [7:0] hr_n;
  logic [5:0] dmax, day_n;
  logic [4:0] mon_n;
  logic [2:0] wd_n;
  logic [7:0] hr_inc;

  assign c_hs  = (hs_q == 8'h99);
  assign c_sec = (sec_q == 8'h59);
  assign c_min = (min_q == 8'h59);
  assign hr_inc = bcd_inc({2'b00, hr_q[5:0]});

  always_comb begin
    hr_n  = hr_q;
    c_day = 1'b0;
    if (!hr_q[7]) begin
      if (hr_q[5:0] == 6'h23) begin
        hr_n[5:0] = 6'h00;
        c_day     = 1'b1;
      end else begin
        hr_n[5:0] = hr_inc[5:0];
      end
    end else begin
      if (hr_q[5:0] == 6'h12) begin
        hr_n[5:0] = 6'h01;
      end else if (hr_q[5:0] == 6'h11) begin
        hr_n[5:0] = 6'h12;
        hr_n[6]   = ~hr_q[6];
        c_day     = hr_q[6];
      end else begin
        hr_n[5:0] = hr_inc[5:0];
      end
    end
  end

  always_comb begin
    unique case (wm_q[4:0])
      5'h02:                      dmax = (yd_q[7:6] == 2'd0) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: dmax = 6'h30;
      default:                    dmax = 6'h31;
    endcase
  end

  logic [7:0] day_inc, mon_inc;
  assign day_inc = bcd_inc({2'b00, yd_q[5:0]});
  assign mon_inc = bcd_inc({3'b000, wm_q[4:0]});
  assign c_mon   = (yd_q[5:0] == dmax);
  assign day_n   = c_mon ? 6'h01 : day_inc[5:0];
  assign c_yr    = (wm_q[4:0] == 5'h12);
  assign mon_n   = c_yr ? 5'h01 : mon_inc[4:0];
  assign wd_n    = (wm_q[7:5] == 3'd6) ? 3'd0 : wm_q[7:5] + 3'd1;

  assign roll_h = tick && c_hs && c_sec && c_min;
  assign roll_d = roll_h && c_day;
  assign roll_m = roll_d && c_mon;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      hs_q  <= 8'h00;
      sec_q <= 8'h00;
      min_q <= 8'h00;
      hr_q  <= 8'h00;
      yd_q  <= 8'h01;
      wm_q  <= 8'h01;
    end else begin
      if (stop_i || div_q == DIV_LAST) div_q <= '0;
      else                             div_q <= div_q + DW'(1);

      if (tick)          hs_q  <= c_hs ? 8'h00 : bcd_inc(hs_q);
      if (tick && c_hs)  sec_q <= c_sec ? 8'h00 : bcd_inc(sec_q);
      if (tick && c_hs && c_sec) min_q <= c_min ? 8'h00 : bcd_inc(min_q);
      if (roll_h)        hr_q  <= hr_n;
      if (roll_d) begin
        yd_q[5:0] <= day_n;
        wm_q[7:5] <= wd_n;
      end
      if (roll_m) begin
        wm_q[4:0] <= mon_n;
        if (c_yr) yd_q[7:6] <= yd_q[7:6] + 2'd1;
      end

      if (wr_en_i) begin
        case (wr_addr_i)
          3'd0: hs_q  <= wr_data_i;
          3'd1: sec_q <= wr_data_i;
          3'd2: min_q <= wr_data_i;
          3'd3: hr_q  <= wr_data_i;
          3'd4: yd_q  <= wr_data_i;
          3'd5: wm_q  <= wr_data_i;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_hs  <= 8'h00;
      cap_sec <= 8'h00;
      cap_min <= 8'h00;
      cap_hr  <= 8'h00;
      cap_yd  <= 8'h01;
      cap_wm  <= 8'h01;
    end else if (rd_start_i && !hold_i) begin
      cap_hs  <= hs_q;
      cap_sec <= sec_q;
      cap_min <= min_q;
      cap_hr  <= hr_q;
      cap_yd  <= yd_q;
      cap_wm  <= wm_q;
    end
  end

  always_comb begin
    case (rd_addr_i)
      3'd0:    rd_data_o = cap_hs;
      3'd1:    rd_data_o = cap_sec;
      3'd2:    rd_data_o = cap_min;
      3'd3:    rd_data_o = cap_hr;
      3'd4:    rd_data_o = {mask_i ? 2'b00 : cap_yd[7:6], cap_yd[5:0]};
      3'd5:    rd_data_o = {mask_i ? 3'b000 : cap_wm[7:5], cap_wm[4:0]};
      default: rd_data_o = 8'h00;
    endcase
  end

  p_hs_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en_i && hs_q == 8'h99) |=> (hs_q == 8'h00));

  p_pm_to_am_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (roll_h && !wr_en_i && hr_q == 8'hD1) |=> (hr_q == 8'h92));

  p_feb_leap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (roll_d && !wr_en_i && wm_q[4:0] == 5'h02 && yd_q == 8'h28) |=> (yd_q[5:0] == 6'h29));

  p_wd_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (roll_d && !wr_en_i && wm_q[7:5] == 3'd6) |=> (wm_q[7:5] == 3'd0));

  p_hold_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> $stable(cap_hs));

  p_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !wr_en_i) |=> $stable(hs_q));

  p_tick_gap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: tb/bcd_rtc_chain_tb.sv
module bcd_rtc_chain_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop_i = 1'b1, hold_i = 1'b0, mask_i = 1'b0;
  logic       wr_en_i = 1'b0, rd_start_i = 1'b0;
  logic [2:0] wr_addr_i = '0, rd_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;

  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_rtc_chain #(.TICK_DIV(DIV)) u_dut (.*);

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk); wr_en_i = 1'b0;
  endtask

  task automatic snap();
    @(negedge clk); rd_start_i = 1'b1;
    @(negedge clk); rd_start_i = 1'b0;
  endtask

  task automatic look(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); rd_addr_i = a; #1 v = rd_data_o;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    snap();
    look(a, v);
  endtask

  task automatic run(input int ticks);
    @(negedge clk); stop_i = 1'b0;
    repeat (ticks * DIV) @(posedge clk);
    @(negedge clk); stop_i = 1'b1;
  endtask

  task automatic load(input logic [7:0] hs, s, m, h, yd, wm);
    wr(0, hs); wr(1, s); wr(2, m); wr(3, h); wr(4, yd); wr(5, wm);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(0, v); chk("R1 hundredths", v, 8'h00);
    look(1, v); chk("R1 seconds", v, 8'h00);
    look(2, v); chk("R1 minutes", v, 8'h00);
    look(3, v); chk("R1 hours", v, 8'h00);
    look(4, v); chk("R1 year/date", v, 8'h01);
    look(5, v); chk("R1 weekday/month", v, 8'h01);
  endtask

  task automatic t_prescale();
    logic [7:0] v;
    @(negedge clk); stop_i = 1'b0;
    repeat (DIV - 1) @(posedge clk);
    @(negedge clk); stop_i = 1'b1;
    rd(0, v); chk("R10 no tick before full period", v, 8'h00);
    run(1);
    rd(0, v); chk("R10 R12 one tick after restart", v, 8'h01);
    run(5);
    rd(0, v); chk("R12 five ticks", v, 8'h06);
  endtask

  task automatic t_ripple();
    logic [7:0] v;
    load(8'h98, 8'h59, 8'h59, 8'h05, 8'h01, 8'h01);
    run(2);
    rd(0, v); chk("R2 hundredths wrap", v, 8'h00);
    look(1, v); chk("R2 seconds wrap", v, 8'h00);
    look(2, v); chk("R2 minutes wrap", v, 8'h00);
    look(3, v); chk("R2 hour carry", v, 8'h06);
    load(8'h09, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01);
    run(1);
    rd(0, v); chk("R2 BCD digit carry", v, 8'h10);
  endtask

  task automatic t_24h();
    logic [7:0] v;
    load(8'h99, 8'h59, 8'h59, 8'h63, 8'h01, 8'h01);
    run(1);
    rd(3, v); chk("R3 23->00 keeps PM bit", v, 8'h40);
    look(4, v); chk("R3 date carry", v, 8'h02);
    look(5, v); chk("R6 weekday steps with date", v, 8'h21);
  endtask

  task automatic t_12h();
    logic [7:0] v;
    load(8'h99, 8'h59, 8'h59, 8'h91, 8'h05, 8'h01);
    run(1);
    rd(3, v); chk("R4 11AM->12PM", v, 8'hD2);
    look(4, v); chk("R4 no date carry at noon", v, 8'h05);
    load(8'h99, 8'h59, 8'h59, 8'hD2, 8'h05, 8'h01);
    run(1);
    rd(3, v); chk("R4 12PM->01PM", v, 8'hC1);
    load(8'h99, 8'h59, 8'h59, 8'hD1, 8'h05, 8'h01);
    run(1);
    rd(3, v); chk("R4 11PM->12AM", v, 8'h92);
    look(4, v); chk("R4 date carry at midnight", v, 8'h06);
  endtask

  task automatic day_case(input string req, input logic [7:0] yd, wm, exp_yd, exp_wm);
    logic [7:0] v;
    load(8'h99, 8'h59, 8'h59, 8'h23, yd, wm);
    run(1);
    rd(4, v); chk({req, " date"}, v, exp_yd);
    look(5, v); chk({req, " month"}, v, exp_wm);
  endtask

  task automatic t_months();
    day_case("R5 Apr 30", 8'h30, 8'h04, 8'h01, 8'h25);
    day_case("R5 May 30", 8'h30, 8'h05, 8'h31, 8'h25);
    day_case("R5 Feb 28 y1", 8'h68, 8'h02, 8'h41, 8'h23);
    day_case("R5 Feb 28 y0", 8'h28, 8'h02, 8'h29, 8'h22);
    day_case("R5 Feb 29 y0", 8'h29, 8'h02, 8'h01, 8'h23);
    day_case("R6 Dec 31 y3 wd6", 8'hF1, 8'hD2, 8'h01, 8'h01);
    day_case("R6 Dec 31 y1 wd5", 8'h71, 8'hB2, 8'h81, 8'hC1);
  endtask

  task automatic t_mask();
    logic [7:0] v;
    load(8'h00, 8'h00, 8'h00, 8'h45, 8'h71, 8'hB2);
    snap();
    mask_i = 1'b1;
    look(4, v); chk("R7 masked year", v, 8'h31);
    look(5, v); chk("R7 masked weekday", v, 8'h12);
    look(3, v); chk("R7 hours unmasked", v, 8'h45);
    mask_i = 1'b0;
    look(4, v); chk("R7 unmasked year", v, 8'h71);
  endtask

  task automatic t_capture();
    logic [7:0] v;
    load(8'h10, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01);
    rd(0, v); chk("R8 snapshot", v, 8'h10);
    run(3);
    look(0, v); chk("R8 no strobe keeps snapshot", v, 8'h10);
    rd(0, v); chk("R8 new snapshot", v, 8'h13);
    hold_i = 1'b1;
    run(2);
    rd(0, v); chk("R9 hold freezes capture", v, 8'h13);
    hold_i = 1'b0;
    rd(0, v); chk("R9 release hold", v, 8'h15);
  endtask

  task automatic t_write();
    logic [7:0] v;
    load(8'h11, 8'h22, 8'h33, 8'h12, 8'h15, 8'h27);
    wr(2, 8'h44);
    wr(6, 8'hAA);
    wr(7, 8'h55);
    rd(0, v); chk("R11 hundredths untouched", v, 8'h11);
    look(1, v); chk("R11 seconds untouched", v, 8'h22);
    look(2, v); chk("R11 minutes written", v, 8'h44);
    look(3, v); chk("R11 hours untouched", v, 8'h12);
    look(4, v); chk("R11 date untouched", v, 8'h15);
    look(5, v); chk("R11 month untouched", v, 8'h27);
    look(6, v); chk("R11 addr 6 reads zero", v, 8'h00);
    look(7, v); chk("R11 addr 7 reads zero", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_prescale();
    t_ripple();
    t_24h();
    t_12h();
    t_months();
    t_mask();
    t_capture();
    t_write();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule